// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block refills cache lines after a miss. It is the part of a non-blocking cache that talks to memory. Each line holds 16 words of 32 bits. Memory returns a line one word per beat over a 32-bit bus. The first beat comes 10 cycles after the request and each later beat follows 2 cycles after the one before it.

The block holds a small pool of miss entries. Each entry owns a line address, a start offset, a beat counter, a per-word valid mask and a line buffer. When a miss is accepted, the block issues a memory request carrying the entry number and the word the memory must start from. Each returning beat is tagged with its entry number. The block places the beat at the right word of that entry's buffer.

When the policy allows it, the block pulses a restart with the requested word so the stalled processor can resume. Three policies are offered:
- **Critical-word-first:** memory starts at the requested word and wraps around, and the restart comes on the first beat.
- **Early restart:** memory starts at word 0, and the restart comes on the beat that carries the requested word.
- **Baseline:** memory starts at word 0, and the restart waits for the whole line.

A done pulse marks the last beat. Words that have already landed in a partly filled line can be read through a lookup port.

Top module: `cwf_refill`

## Requirements
- R1: After reset no entry is busy, `missReady` is 1, `restartValid`, `doneValid` and `lkHit` are 0.
- R2: A miss is accepted in any cycle where `missValid` and `missReady` are both 1. In that same cycle `memReqValid` is 1, `memReqId` is the lowest-numbered idle entry, and `memReqLine` equals `missLine`. `memReqStart` equals `missWord` when `missMode` is 0 (critical-word-first), and is 0 when `missMode` is 1 (early restart) or 2 or 3 (baseline).
- R3: The k-th beat of an entry (k counted from 0) is stored as word (start + k) mod 16 of that entry's line.
- R4: In mode 0, `restartValid` pulses in the cycle after beat 0 of the entry. It carries that entry's number in `restartId` and the requested word's data in `restartData`.
- R5: In mode 1, the restart pulse comes in the cycle after the beat whose word index equals the requested word. It carries the same data as in R4.
- R6: In modes 2 and 3, the restart pulse comes in the cycle after the 16th beat. It carries the requested word's data.
- R7: `doneValid` pulses with `doneId` in the cycle after an entry's 16th beat. The entry is idle from that cycle on.
- R8: When all entries are busy, `missReady` is 0. A miss presented then raises no `memReqValid` and changes no state.
- R9: A beat with `retValid` set whose `retId` names an idle entry is ignored. It produces no restart, no done and no buffer write.
- R10: `lkHit` is 1 and `lkData` is the word when a busy entry holds `lkLine` and word `lkWord` was written by an earlier beat. The word becomes visible from the cycle after its beat.
- R11: Several entries fill at the same time, with beats from different entries interleaved on the return bus. Each entry completes independently.
- R12: When memory keeps to its nominal timing, the restart appears a fixed number of cycles after the request. This is 11 cycles in mode 0, 11 + 2·w cycles in mode 1 for requested word w, and 41 cycles in modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| missValid | input | 1 | Miss request present |
| missLine | input | LINE_W | Line address of the miss |
| missWord | input | 4 | Requested word within the line |
| missMode | input | 2 | 0 critical-word-first, 1 early restart, 2/3 baseline |
| missReady | output | 1 | An entry is free |
| memReqValid | output | 1 | Memory request issued this cycle |
| memReqId | output | 2 | Entry number tagging the request |
| memReqLine | output | LINE_W | Line to fetch |
| memReqStart | output | 4 | Word the memory must deliver first |
| retValid | input | 1 | Return beat present |
| retId | input | 2 | Entry the beat belongs to |
| retData | input | 32 | Beat data |
| lkLine | input | LINE_W | Lookup line address |
| lkWord | input | 4 | Lookup word |
| lkHit | output | 1 | Looked-up word is present in a filling line |
| lkData | output | 32 | Looked-up word |
| restartValid | output | 1 | Processor restart pulse |
| restartId | output | 2 | Entry that restarts |
| restartData | output | 32 | Requested word |
| doneValid | output | 1 | Line complete pulse |
| doneId | output | 2 | Entry that completed |

## Verification
A wrong beat counter or start offset in an entry shows up in one of two ways. Either a restart carries the wrong word's data in the cycle after the triggering beat, or a lookup returns a word in the wrong position one cycle after the beat lands. The bench sweeps the lookup word every cycle, so a misplaced word is seen within a line's fill. A stuck busy flag or a bad free-entry pick shows at once on `missReady` and `memReqId` in the request cycle. A missed retirement shows as an absent done pulse on the cycle after the 16th beat.

// File: rtl/refill_pkg.sv
package refill_pkg;
  parameter int DATA_W  = 32;
  parameter int WORDS   = 16;
  parameter int ENTRIES = 4;
  localparam int WORD_W = $clog2(WORDS);
  localparam int ID_W   = $clog2(ENTRIES);

  localparam logic [1:0] MODE_CWF = 2'd0;
  localparam logic [1:0] MODE_ER  = 2'd1;

  // strobes from control to datapath
  typedef struct packed {
    logic              wr;
    logic              last;
    logic              fire;
    logic [ID_W-1:0]   wrId;
    logic [WORD_W-1:0] wrWord;
    logic [WORD_W-1:0] critWord;
    logic              clr;
    logic [ID_W-1:0]   clrId;
    logic              lkAny;
    logic [ID_W-1:0]   lkId;
  } strobe_t;
endpackage

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              missValid,
  input  logic [LINE_W-1:0] missLine,
  input  logic [WORD_W-1:0] missWord,
  input  logic [1:0]        missMode,
  output logic              missReady,
  output logic              memReqValid,
  output logic [ID_W-1:0]   memReqId,
  output logic [LINE_W-1:0] memReqLine,
  output logic [WORD_W-1:0] memReqStart,
  input  logic              retValid,
  input  logic [ID_W-1:0]   retId,
  input  logic [LINE_W-1:0] lkLine,
  output strobe_t           st,
  output logic              restartValid,
  output logic [ID_W-1:0]   restartId,
  output logic              doneValid,
  output logic [ID_W-1:0]   doneId
);
  logic [ENTRIES-1:0] busy;
  logic [LINE_W-1:0]  lineTag [ENTRIES];
  logic [WORD_W-1:0]  startW  [ENTRIES];
  logic [WORD_W-1:0]  critW   [ENTRIES];
  logic [WORD_W-1:0]  beatCnt [ENTRIES];
  logic [1:0]         modeR   [ENTRIES];

  logic [ID_W-1:0]   freeId;
  logic              accept, retOk, isLast, fireNow;
  logic [WORD_W-1:0] curWord, startSel;
  logic              lkAny;
  logic [ID_W-1:0]   lkId;

  // lowest-numbered idle entry
  always_comb begin
    freeId = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!busy[i]) freeId = ID_W'(i);
  end

  assign missReady   = ~&busy;
  assign accept      = missValid && missReady;
  assign startSel    = (missMode == MODE_CWF) ? missWord : '0;
  assign memReqValid = accept;
  assign memReqId    = freeId;
  assign memReqLine  = missLine;
  assign memReqStart = startSel;

  assign retOk   = retValid && busy[retId];
  assign curWord = startW[retId] + beatCnt[retId];
  assign isLast  = beatCnt[retId] == WORD_W'(WORDS - 1);

  always_comb begin
    case (modeR[retId])
      MODE_CWF: fireNow = beatCnt[retId] == '0;
      MODE_ER:  fireNow = curWord == critW[retId];
      default:  fireNow = isLast;
    endcase
  end

  always_comb begin
    lkAny = 1'b0;
    lkId  = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (busy[i] && lineTag[i] == lkLine) begin
        lkAny = 1'b1;
        lkId  = ID_W'(i);
      end
  end

  always_comb begin
    st.wr       = retOk;
    st.last     = isLast;
    st.fire     = fireNow;
    st.wrId     = retId;
    st.wrWord   = curWord;
    st.critWord = critW[retId];
    st.clr      = accept;
    st.clrId    = freeId;
    st.lkAny    = lkAny;
    st.lkId     = lkId;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= '0;
      restartValid <= 1'b0;
      restartId    <= '0;
      doneValid    <= 1'b0;
      doneId       <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        lineTag[i] <= '0;
        startW[i]  <= '0;
        critW[i]   <= '0;
        beatCnt[i] <= '0;
        modeR[i]   <= '0;
      end
    end else begin
      restartValid <= retOk && fireNow;
      restartId    <= retId;
      doneValid    <= retOk && isLast;
      doneId       <= retId;
      if (retOk) begin
        beatCnt[retId] <= beatCnt[retId] + 1'b1;
        if (isLast) busy[retId] <= 1'b0;
      end
      if (accept) begin
        busy[freeId]    <= 1'b1;
        lineTag[freeId] <= missLine;
        startW[freeId]  <= startSel;
        critW[freeId]   <= missWord;
        modeR[freeId]   <= missMode;
        beatCnt[freeId] <= '0;
      end
    end
  end

  AST_ALLOC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |=> busy[$past(memReqId)]); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> !busy[doneId]); // R7
  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy) |-> !memReqValid); // R8
endmodule

// File: rtl/refill_data.sv
module refill_data
  import refill_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] retData,
  input  logic [WORD_W-1:0] lkWord,
  output logic              lkHit,
  output logic [DATA_W-1:0] lkData,
  output logic [DATA_W-1:0] restartData
);
  logic [ENTRIES-1:0][WORDS-1:0] mask;
  logic [DATA_W-1:0] lineBuf [ENTRIES][WORDS];

  always_ff @(posedge clk) begin
    if (st.wr) lineBuf[st.wrId][st.wrWord] <= retData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask        <= '0;
      restartData <= '0;
    end else begin
      if (st.clr) mask[st.clrId] <= '0;
      if (st.wr)  mask[st.wrId][st.wrWord] <= 1'b1;
      if (st.wr && st.fire)
        restartData <= (st.wrWord == st.critWord) ? retData
                                                  : lineBuf[st.wrId][st.critWord];
    end
  end

  assign lkHit  = st.lkAny && mask[st.lkId][lkWord];
  assign lkData = lineBuf[st.lkId][lkWord];

  AST_WRITE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    st.wr |-> !mask[st.wrId][st.wrWord]); // R3
  AST_FULL_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st.wr && st.last) |-> ($countones(mask[st.wrId]) == WORDS - 1)); // R7
endmodule

// File: rtl/cwf_refill.sv
module cwf_refill
  import refill_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              missValid,
  input  logic [LINE_W-1:0] missLine,
  input  logic [WORD_W-1:0] missWord,
  input  logic [1:0]        missMode,
  output logic              missReady,
  output logic              memReqValid,
  output logic [ID_W-1:0]   memReqId,
  output logic [LINE_W-1:0] memReqLine,
  output logic [WORD_W-1:0] memReqStart,
  input  logic              retValid,
  input  logic [ID_W-1:0]   retId,
  input  logic [DATA_W-1:0] retData,
  input  logic [LINE_W-1:0] lkLine,
  input  logic [WORD_W-1:0] lkWord,
  output logic              lkHit,
  output logic [DATA_W-1:0] lkData,
  output logic              restartValid,
  output logic [ID_W-1:0]   restartId,
  output logic [DATA_W-1:0] restartData,
  output logic              doneValid,
  output logic [ID_W-1:0]   doneId
);
  strobe_t st;

  refill_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .missValid(missValid), .missLine(missLine), .missWord(missWord),
    .missMode(missMode), .missReady(missReady),
    .memReqValid(memReqValid), .memReqId(memReqId),
    .memReqLine(memReqLine), .memReqStart(memReqStart),
    .retValid(retValid), .retId(retId), .lkLine(lkLine), .st(st),
    .restartValid(restartValid), .restartId(restartId),
    .doneValid(doneValid), .doneId(doneId)
  );

  refill_data u_data (
    .clk(clk), .rst_n(rst_n), .st(st), .retData(retData),
    .lkWord(lkWord), .lkHit(lkHit), .lkData(lkData),
    .restartData(restartData)
  );
endmodule

// File: tb/cwf_refill_bench.sv
module cwf_refill_bench;
  localparam int LW = 26;

  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n;
  logic missValid;
  logic [LW-1:0] missLine;
  logic [3:0] missWord;
  logic [1:0] missMode;
  logic missReady, memReqValid;
  logic [1:0] memReqId;
  logic [LW-1:0] memReqLine;
  logic [3:0] memReqStart;
  logic retValid;
  logic [1:0] retId;
  logic [31:0] retData;
  logic [LW-1:0] lkLine;
  logic [3:0] lkWord;
  logic lkHit;
  logic [31:0] lkData;
  logic restartValid;
  logic [1:0] restartId;
  logic [31:0] restartData;
  logic doneValid;
  logic [1:0] doneId;

  cwf_refill u_cwf_refill (.*);

  int nChecks = 0, nFail = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  bit mBusy[4];
  int mLine[4], mStart[4], mCrit[4], mMode[4], mCnt[4];
  bit [15:0] mMask[4];
  logic [31:0] mData[4][16];
  bit eRV, eDV;
  int eRId, eDId;
  logic [31:0] eRD;
  string eRTag;

  // memory model
  int qId[$], qDue[$];
  logic [31:0] qData[$];
  int strayId = -1;
  int reqCyc[4];
  int lastLat = -1, doneCount = 0;

  function automatic logic [31:0] memWord(logic [LW-1:0] line, int w);
    return 32'hC0DE0000 ^ {2'b00, line, w[3:0]};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int modelFree();
    int f = -1;
    for (int i = 3; i >= 0; i--) if (!mBusy[i]) f = i;
    return f;
  endfunction

  task automatic step();
    int best = -1;
    int fid;
    bit expHit = 0;
    logic [31:0] expLk = '0;
    lkWord = 4'(cyc % 16);
    retValid = 0; retId = 0; retData = 0;
    for (int i = 0; i < qId.size(); i++)
      if (qDue[i] <= cyc && (best < 0 || qDue[i] < qDue[best])) best = i;
    if (best >= 0) begin
      retValid = 1; retId = 2'(qId[best]); retData = qData[best];
      qId.delete(best); qDue.delete(best); qData.delete(best);
    end else if (strayId >= 0) begin
      retValid = 1; retId = 2'(strayId); retData = 32'hDEADBEEF;
    end
    #1;
    fid = modelFree();
    chk(missReady == (fid >= 0), "R8", "missReady", missReady, fid >= 0);
    chk(memReqValid == (missValid && fid >= 0), "R2", "memReqValid", memReqValid, missValid && fid >= 0);
    if (memReqValid && fid >= 0) begin
      chk(memReqId == 2'(fid), "R2", "memReqId", memReqId, fid);
      chk(memReqLine == missLine, "R2", "memReqLine", memReqLine, missLine);
      chk(memReqStart == ((missMode == 0) ? missWord : 4'd0), "R2", "memReqStart",
          memReqStart, (missMode == 0) ? missWord : 0);
    end
    chk(restartValid == eRV, eRTag, "restartValid", restartValid, eRV);
    if (eRV) begin
      chk(restartId == 2'(eRId), eRTag, "restartId", restartId, eRId);
      chk(restartData == eRD, eRTag, "restartData", restartData, eRD);
    end
    chk(doneValid == eDV, "R7", "doneValid", doneValid, eDV);
    if (eDV) chk(doneId == 2'(eDId), "R7", "doneId", doneId, eDId);
    for (int i = 0; i < 4; i++)
      if (mBusy[i] && mLine[i] == int'(lkLine) && mMask[i][lkWord]) begin
        expHit = 1; expLk = mData[i][lkWord];
      end
    chk(lkHit == expHit, "R10", "lkHit", lkHit, expHit);
    if (expHit) chk(lkData == expLk, "R3", "lkData", lkData, expLk);
    // memory takes the request, latency bookkeeping
    if (memReqValid) begin
      reqCyc[memReqId] = cyc;
      for (int k = 0; k < 16; k++) begin
        qId.push_back(int'(memReqId));
        qDue.push_back(cyc + 10 + 2 * k);
        qData.push_back(memWord(memReqLine, (int'(memReqStart) + k) % 16));
      end
    end
    if (restartValid) lastLat = cyc - reqCyc[restartId];
    if (doneValid) doneCount++;
    @(posedge clk);
    // model update
    eRV = 0; eDV = 0;
    if (retValid && mBusy[retId]) begin
      int id = int'(retId);
      int w = (mStart[id] + mCnt[id]) % 16;
      bit fire;
      mData[id][w] = retData;
      mMask[id][w] = 1'b1;
      fire = (mMode[id] == 0) ? (mCnt[id] == 0) :
             (mMode[id] == 1) ? (w == mCrit[id]) : (mCnt[id] == 15);
      if (fire) begin
        eRV = 1; eRId = id; eRD = mData[id][mCrit[id]];
        eRTag = (mMode[id] == 0) ? "R4" : (mMode[id] == 1) ? "R5" : "R6";
      end
      if (mCnt[id] == 15) begin
        eDV = 1; eDId = id; mBusy[id] = 0;
      end
      mCnt[id]++;
    end
    if (missValid && fid >= 0) begin
      mBusy[fid] = 1; mLine[fid] = int'(missLine); mCrit[fid] = int'(missWord);
      mMode[fid] = int'(missMode); mStart[fid] = (missMode == 0) ? int'(missWord) : 0;
      mCnt[fid] = 0; mMask[fid] = '0;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic miss(int line, int w, int mode);
    missValid = 1; missLine = LW'(line); missWord = 4'(w); missMode = 2'(mode);
    step();
    missValid = 0;
  endtask

  function automatic bit anyBusy();
    for (int i = 0; i < 4; i++) if (mBusy[i]) return 1;
    return 0;
  endfunction

  task automatic drain();
    for (int n = 0; n < 300 && (anyBusy() || qId.size() > 0 || eRV || eDV); n++) step();
  endtask

  task automatic single(int line, int w, int mode, int lat, string tag);
    lkLine = LW'(line);
    lastLat = -1;
    miss(line, w, mode);
    drain();
    chk(lastLat == lat, tag, "restart latency", lastLat, lat);
    chk(lastLat == lat, "R12", "restart latency", lastLat, lat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    eRTag = "R4";
    rst_n = 0; missValid = 0; missLine = 0; missWord = 0; missMode = 0;
    retValid = 0; retId = 0; retData = 0; lkLine = 0; lkWord = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(missReady == 1, "R1", "missReady after reset", missReady, 1);
    chk(restartValid == 0 && doneValid == 0, "R1", "pulses after reset",
        {restartValid, doneValid}, 0);
    chk(lkHit == 0, "R1", "lkHit after reset", lkHit, 0);
    @(negedge clk);
    step();

    // critical-word-first: restart on beat 0, wrap order
    single(100, 5, 0, 11, "R4");
    single(101, 15, 0, 11, "R4");
    single(102, 0, 0, 11, "R4");
    // early restart: natural order
    single(200, 5, 1, 21, "R5");
    single(201, 15, 1, 41, "R5");
    single(202, 0, 1, 11, "R5");
    // baseline
    single(300, 3, 2, 41, "R6");
    single(301, 9, 3, 41, "R6");

    // stray beats for idle entries while entry 0 fills
    lkLine = LW'(400);
    miss(400, 7, 0);
    strayId = 1;
    repeat (6) begin
      step();
      chk(doneValid == 0, "R9", "done after stray beat", doneValid, 0);
    end
    strayId = -1;
    drain();
    strayId = 3;
    step();
    strayId = -1;
    step();
    chk(restartValid == 0 && doneValid == 0, "R9", "pulses after stray beat",
        {restartValid, doneValid}, 0);

    // four concurrent misses, then a refused fifth
    doneCount = 0;
    lkLine = LW'(502);
    miss(500, 4, 0);
    miss(501, 11, 1);
    miss(502, 2, 2);
    miss(503, 13, 0);
    for (int k = 0; k < 3; k++) begin
      missValid = 1; missLine = LW'(599); missWord = 4'd1; missMode = 2'd0;
      #1;
      chk(missReady == 0 && memReqValid == 0, "R8", "refused when full",
          {missReady, memReqValid}, 0);
      step();
    end
    missValid = 0;
    drain();
    chk(doneCount == 4, "R11", "concurrent completions", doneCount, 4);

    // refill after completion reuses entries; overlap two
    doneCount = 0;
    lkLine = LW'(700);
    miss(700, 6, 1);
    step();
    miss(701, 9, 0);
    drain();
    chk(doneCount == 2, "R11", "overlapped completions", doneCount, 2);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule